// File: doc/BRIEF.md
# Event Counter Bank with Per-Counter Width Control

This block holds a parameterised set of programmable event counters. Each counter has a type register that selects which event it counts. The choices are one of the external event pulse inputs or a software-triggered increment. A counter advances when three things are true in the same cycle: its enable bit is set, its external allow input is high, and its selected event fires. Software programs the bank through one synchronous write port and one combinational read port. The port serves the counters, the type registers, the enable and interrupt-enable set/clear pairs, the overflow-status set/clear pair and a software-increment register.

A counter can overflow in two places. In short mode the flag fires when bit 31 falls from 1 to 0. In long mode it fires when bit 63 falls from 1 to 0. Each counter picks its mode from a global long-mode bit. If a nonzero partition count is programmed in the hypervisor control register, counters at or above that count take their mode from a separate hypervisor long-mode bit instead. A static width strap turns the 64-bit storage on or off. With the strap low, the upper word reads as zero, writes to it are discarded, and every counter behaves as a 32-bit counter. Every overflow sets a sticky status bit, and a single interrupt line reports any status bit whose interrupt enable is also set.

Top module: `pmu_evcnt_bank`

## Requirements
- R1: After reset every counter, type, enable, interrupt-enable and overflow-status register and both control registers read as zero, and `irq` is low.
- R2: Writing 1s to the enable-set register (address 0x02) sets those enable bits, and the enable-clear register (0x03) clears them. The interrupt-enable pair at 0x04/0x05 works the same way. All four writes are masked to bits 0..NUM_CNT-1 plus bit 31. Each set of bits reads back at its set address.
- R3: Counter i (address 0x20+i) increases by exactly one on each clock edge where enable bit i, `cnt_allow[i]` and the selected event are all high. A type value k in 1..NUM_EVT selects `evt_in[k-1]`. Any other nonzero type counts nothing.
- R4: Type code 0 selects software increment. Writing the software-increment register (0x08) with bit i set adds one to counter i only when that counter is enabled, allowed and of type 0.
- R5: With `long_feat` low, a counter's upper 32 bits read as zero, writes to them are discarded, and the counter wraps from 0xFFFFFFFF to 0.
- R6: With `long_feat` high, the long-mode bit is bit 7 of the control register (0x00). A long-mode counter flags overflow only when bit 63 goes from 1 to 0. A short-mode counter flags overflow when bit 31 goes from 1 to 0 and carries into bit 32.
- R7: The hypervisor control register (0x01) holds a partition count in bits [4:0] and a hypervisor long-mode bit at bit 26. When the count is nonzero, counters with index at or above it use bit 26 in place of control bit 7.
- R8: An overflow sets the counter's sticky status bit (read at 0x06). Writing 1s to 0x06 sets status bits. Writing 1s to 0x07 clears them, masked as in R2. A bit stays set until it is cleared.
- R9: `irq` is high exactly when some bit is set in both the interrupt-enable and the overflow-status registers.
- R10: A register write to a counter takes effect in place of any increment in that same cycle.
- R11: A type register (address 0x40+i) keeps the low 10 bits of the written value and reads zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| long_feat | input | 1 | Strap enabling 64-bit counter storage |
| cnt_allow | input | NUM_CNT | Per-counter count permission |
| evt_in | input | NUM_EVT | Event pulse inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Write address |
| reg_wdata | input | 64 | Write data |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | 64 | Read data (combinational) |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest situation to reach is an overflow at exactly the bit that the counter's mode selects. This becomes hard under a partition boundary, where neighbouring counters follow different long-mode bits. Counting up from reset to bit 31 or bit 63 is out of reach. The bench instead writes each counter to just below the wrap point, then fires a single software increment. It reads both the resulting counter value and the status bit, which shows both the carry into bit 32 and whether the flag was raised. It then swaps the global and hypervisor mode bits and repeats, so that both sides of the boundary are seen in each mode.

// File: rtl/pmu_evcnt_bank.sv
module pmu_evcnt_bank #(
  parameter int NUM_CNT = 6,
  parameter int NUM_EVT = 8,
  parameter int ADDR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              long_feat,
  input  logic [NUM_CNT-1:0] cnt_allow,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [63:0]       reg_rdata,
  output logic              irq
);
  localparam int TYPE_W = 10;
  localparam logic [31:0] IMPL_MASK = 32'((64'd1 << NUM_CNT) - 64'd1) | 32'h8000_0000;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_HYP   = ADDR_W'(8'h01);
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(8'h02);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(8'h03);
  localparam logic [ADDR_W-1:0] A_IESET = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_IECLR = ADDR_W'(8'h05);
  localparam logic [ADDR_W-1:0] A_OVSET = ADDR_W'(8'h06);
  localparam logic [ADDR_W-1:0] A_OVCLR = ADDR_W'(8'h07);
  localparam logic [ADDR_W-1:0] A_SWINC = ADDR_W'(8'h08);
  localparam int A_CNT  = 32;
  localparam int A_TYPE = 64;

  logic              ctrl_long, hyp_long;
  logic [4:0]        hpmn;
  logic [31:0]       en_q, ien_q, ovs_q;
  logic [63:0]       cnt_q  [NUM_CNT];
  logic [TYPE_W-1:0] type_q [NUM_CNT];

  logic [63:0]       cnt_nxt [NUM_CNT];
  logic [NUM_CNT-1:0] step, wrap, wr_cnt, wr_type, is_long;

  wire swinc_wr = reg_we && (reg_addr == A_SWINC);
  wire [31:0] wmask = reg_wdata[31:0] & IMPL_MASK;

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      logic hit;
      hit = (type_q[i] == '0) && swinc_wr && reg_wdata[i];
      for (int k = 0; k < NUM_EVT; k++)
        if (type_q[i] == TYPE_W'(k + 1) && evt_in[k]) hit = 1'b1;
      is_long[i] = long_feat &&
                   (((hpmn != 5'd0) && (5'(i) >= hpmn)) ? hyp_long : ctrl_long);
      step[i]    = en_q[i] && cnt_allow[i] && hit;
      cnt_nxt[i] = long_feat ? cnt_q[i] + 64'd1 : {32'd0, cnt_q[i][31:0] + 32'd1};
      wrap[i]    = step[i] && (is_long[i] ? (cnt_q[i][63] && !cnt_nxt[i][63])
                                          : (cnt_q[i][31] && !cnt_nxt[i][31]));
      wr_cnt[i]  = reg_we && (reg_addr == ADDR_W'(A_CNT + i));
      wr_type[i] = reg_we && (reg_addr == ADDR_W'(A_TYPE + i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_long <= 1'b0;
      hyp_long  <= 1'b0;
      hpmn      <= '0;
      en_q      <= '0;
      ien_q     <= '0;
      ovs_q     <= '0;
      for (int i = 0; i < NUM_CNT; i++) begin
        cnt_q[i]  <= '0;
        type_q[i] <= '0;
      end
    end else begin
      if (reg_we && reg_addr == A_CTRL) ctrl_long <= reg_wdata[7];
      if (reg_we && reg_addr == A_HYP) begin
        hyp_long <= reg_wdata[26];
        hpmn     <= reg_wdata[4:0];
      end
      if (reg_we && reg_addr == A_ENSET) en_q  <= en_q | wmask;
      if (reg_we && reg_addr == A_ENCLR) en_q  <= en_q & ~wmask;
      if (reg_we && reg_addr == A_IESET) ien_q <= ien_q | wmask;
      if (reg_we && reg_addr == A_IECLR) ien_q <= ien_q & ~wmask;
      ovs_q <= ((ovs_q | ((reg_we && reg_addr == A_OVSET) ? wmask : 32'd0))
                       & ~((reg_we && reg_addr == A_OVCLR) ? wmask : 32'd0))
               | 32'(wrap);
      for (int i = 0; i < NUM_CNT; i++) begin
        if (wr_cnt[i])
          cnt_q[i] <= long_feat ? reg_wdata : {32'd0, reg_wdata[31:0]};
        else if (step[i])
          cnt_q[i] <= cnt_nxt[i];
        if (wr_type[i]) type_q[i] <= reg_wdata[TYPE_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      A_CTRL:  reg_rdata[7] = ctrl_long;
      A_HYP:   begin reg_rdata[26] = hyp_long; reg_rdata[4:0] = hpmn; end
      A_ENSET: reg_rdata[31:0] = en_q;
      A_IESET: reg_rdata[31:0] = ien_q;
      A_OVSET: reg_rdata[31:0] = ovs_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_raddr == ADDR_W'(A_CNT + i))  reg_rdata = cnt_q[i];
      if (reg_raddr == ADDR_W'(A_TYPE + i)) reg_rdata = 64'(type_q[i]);
    end
  end

  assign irq = |(ien_q & ovs_q);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovs_q[g] && !(reg_we && reg_addr == A_OVCLR && reg_wdata[g])) |=> ovs_q[g]);
    assert_wrap_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[g] |=> ovs_q[g]);
    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!long_feat && (wr_cnt[g] || step[g])) |=> (cnt_q[g][63:32] == 32'd0));
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt[g] |=> (cnt_q[g][31:0] == $past(cnt_q[g][31:0]) ||
                      cnt_q[g][31:0] == $past(cnt_q[g][31:0]) + 32'd1));
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[g] && !wr_cnt[g]) |=> $stable(cnt_q[g]));
  end
endmodule

// File: tb/pmu_evcnt_bank_tb.sv
module pmu_evcnt_bank_tb_top;
  localparam int N = 6, NE = 8;
  logic clk = 0, rst_n = 0, long_feat = 1;
  logic [N-1:0]  cnt_allow = '1;
  logic [NE-1:0] evt_in = '0;
  logic reg_we = 0;
  logic [6:0] reg_addr = '0, reg_raddr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pmu_evcnt_bank #(.NUM_CNT(N), .NUM_EVT(NE), .ADDR_W(7)) dut_i (
    .clk(clk), .rst_n(rst_n), .long_feat(long_feat), .cnt_allow(cnt_allow),
    .evt_in(evt_in), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [63:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [63:0] d);
    reg_raddr = a; #1; d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(7'h00, v); chk("R1 ctrl", v, 0);
    rd(7'h02, v); chk("R1 enable", v, 0);
    rd(7'h06, v); chk("R1 status", v, 0);
    rd(7'h20, v); chk("R1 counter0", v, 0);
    rd(7'h41, v); chk("R1 type1", v, 0);
    chk("R1 irq", 64'(irq), 0);
  endtask

  task automatic t_masks;
    logic [63:0] v;
    wr(7'h02, 64'hFFFF_FFFF_FFFF_FFFF); rd(7'h02, v); chk("R2 enset mask", v, 64'h8000_003F);
    wr(7'h03, 64'h1); rd(7'h02, v); chk("R2 enclr", v, 64'h8000_003E);
    wr(7'h04, 64'h4000_0011); rd(7'h04, v); chk("R2 ieset mask", v, 64'h11);
    wr(7'h05, 64'h11); rd(7'h04, v); chk("R2 ieclr", v, 0);
    wr(7'h03, 64'hFFFF_FFFF);
  endtask

  task automatic t_count;
    logic [63:0] v;
    wr(7'h40, 1); wr(7'h41, 3); wr(7'h45, 200);
    wr(7'h02, 64'h23);
    @(negedge clk); evt_in = 8'hFF;
    repeat (5) @(negedge clk);
    evt_in = 0;
    rd(7'h20, v); chk("R3 event count", v, 5);
    rd(7'h21, v); chk("R3 other event", v, 5);
    rd(7'h25, v); chk("R3 out-of-range type", v, 0);
    cnt_allow = 6'b111110;
    @(negedge clk); evt_in = 8'h01; @(negedge clk); evt_in = 0;
    rd(7'h20, v); chk("R3 allow low", v, 5);
    cnt_allow = '1;
  endtask

  task automatic t_swinc;
    logic [63:0] v;
    wr(7'h42, 0); wr(7'h43, 0);
    wr(7'h02, 64'h04);
    wr(7'h08, 64'h0D);
    rd(7'h22, v); chk("R4 swinc enabled", v, 1);
    rd(7'h23, v); chk("R4 swinc disabled", v, 0);
    rd(7'h20, v); chk("R4 wrong type", v, 5);
  endtask

  task automatic t_strap;
    logic [63:0] v;
    long_feat = 0;
    wr(7'h44, 0); wr(7'h02, 64'h10);
    wr(7'h24, 64'hAAAA_BBBB_FFFF_FFFF);
    rd(7'h24, v); chk("R5 upper discarded", v, 64'hFFFF_FFFF);
    wr(7'h08, 64'h10);
    rd(7'h24, v); chk("R5 wrap 32", v, 0);
    rd(7'h06, v); chk("R5 overflow flag", v & 64'h10, 64'h10);
    long_feat = 1;
    wr(7'h07, 64'hFFFF_FFFF);
  endtask

  task automatic t_long;
    logic [63:0] v;
    wr(7'h00, 64'h80);
    wr(7'h22, 64'hFFFF_FFFF); wr(7'h08, 64'h4);
    rd(7'h22, v); chk("R6 long carry", v, 64'h1_0000_0000);
    rd(7'h06, v); chk("R6 long no flag at 31", v, 0);
    wr(7'h22, 64'hFFFF_FFFF_FFFF_FFFF); wr(7'h08, 64'h4);
    rd(7'h22, v); chk("R6 long wrap", v, 0);
    rd(7'h06, v); chk("R6 long flag", v, 64'h4);
    wr(7'h07, 64'h4); wr(7'h00, 0);
    wr(7'h22, 64'hFFFF_FFFF); wr(7'h08, 64'h4);
    rd(7'h22, v); chk("R6 short carry", v, 64'h1_0000_0000);
    rd(7'h06, v); chk("R6 short flag", v, 64'h4);
    wr(7'h07, 64'hFFFF_FFFF);
  endtask

  task automatic t_partition;
    logic [63:0] v;
    wr(7'h02, 64'h14);
    wr(7'h00, 64'h80); wr(7'h01, 64'h3);
    wr(7'h22, 64'hFFFF_FFFF); wr(7'h24, 64'hFFFF_FFFF); wr(7'h08, 64'h14);
    rd(7'h06, v); chk("R7 low long high short", v, 64'h10);
    rd(7'h24, v); chk("R7 counter4 carry", v, 64'h1_0000_0000);
    wr(7'h07, 64'hFFFF_FFFF);
    wr(7'h00, 0); wr(7'h01, 64'h0400_0003);
    rd(7'h01, v); chk("R7 hyp readback", v, 64'h0400_0003);
    wr(7'h22, 64'hFFFF_FFFF); wr(7'h24, 64'hFFFF_FFFF); wr(7'h08, 64'h14);
    rd(7'h06, v); chk("R7 swapped modes", v, 64'h04);
    wr(7'h07, 64'hFFFF_FFFF); wr(7'h01, 0);
  endtask

  task automatic t_sticky_irq;
    logic [63:0] v;
    wr(7'h06, 64'h8000_0002);
    rd(7'h06, v); chk("R8 set", v, 64'h8000_0002);
    @(negedge clk); @(negedge clk);
    rd(7'h06, v); chk("R8 sticky", v, 64'h8000_0002);
    chk("R9 irq masked", 64'(irq), 0);
    wr(7'h04, 64'h2); #1; chk("R9 irq on", 64'(irq), 1);
    wr(7'h07, 64'h2); #1; chk("R9 irq off", 64'(irq), 0);
    rd(7'h06, v); chk("R8 clear", v, 64'h8000_0000);
    wr(7'h07, 64'hFFFF_FFFF); wr(7'h05, 64'hFFFF_FFFF);
  endtask

  task automatic t_priority;
    logic [63:0] v;
    wr(7'h02, 64'h1);
    @(negedge clk); evt_in = 8'h01;
    wr(7'h20, 100);
    rd(7'h20, v); chk("R10 write wins", v, 100);
    @(negedge clk); evt_in = 0;
    rd(7'h20, v); chk("R10 next count", v, 101);
  endtask

  task automatic t_type;
    logic [63:0] v;
    wr(7'h43, 64'hFFFF);
    rd(7'h43, v); chk("R11 type width", v, 64'h3FF);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_masks(); t_count(); t_swinc(); t_strap();
    t_long(); t_partition(); t_sticky_irq(); t_priority(); t_type();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule